// File: doc/BRIEF.md
# Packet-Filter Virtual Machine Arithmetic Unit

This block is the arithmetic and logic execution stage of a 64-bit register-machine instruction set used by in-kernel packet filters. Each operation is issued with a single `start` strobe. With it come a 4-bit operation code, the current destination value, a register source, a 32-bit immediate, a bit that picks the register or the immediate as source, and a bit that picks the 64-bit or the 32-bit instruction class. The unit returns the new destination value on `result`, with a one-cycle `done` pulse.

Most operations finish one cycle after `start`. Unsigned divide and unsigned modulo use an iterative restoring divider that retires one quotient bit per clock: 64 steps in the 64-bit class and 32 steps in the 32-bit class. A zero divisor is detected when the operation is issued, and that operation then finishes in one cycle. Arithmetic wraps silently and never traps.

The controller has three states. IDLE waits for `start`. DIVIDE runs the divider steps. FINISH writes the quotient or remainder. The transitions are:
- IDLE→DIVIDE on an accepted divide or modulo with a non-zero divisor.
- DIVIDE→FINISH on the final divider step.
- FINISH→IDLE unconditionally.
- IDLE→IDLE for every one-cycle operation, and while no start is present.

Top module: `pfvm_alu`

## Requirements
- R1: While reset is asserted and after it is released, `done` is low and `result` is zero until the first operation completes.
- R2: Operation codes are ADD=0x0, SUB=0x1, MUL=0x2, DIV=0x3, OR=0x4, AND=0x5, LSH=0x6, RSH=0x7, NEG=0x8, MOD=0x9, XOR=0xa, MOV=0xb, ARSH=0xc. Every operation other than DIV or MOD with a non-zero divisor raises `done` for one cycle, in the cycle right after the clock edge that samples `start`.
- R3: ADD, SUB and MUL wrap modulo 2^64 in the 64-bit class and modulo 2^32 in the 32-bit class. MUL keeps the low half of the product.
- R4: OR, AND and XOR combine the destination and the source bitwise. MOV returns the source.
- R5: LSH and RSH are logical shifts of the destination. ARSH fills vacated bits with the sign bit of the operand: bit 63 in the 64-bit class, bit 31 in the 32-bit class. The shift count is the low 6 bits of the source in the 64-bit class and the low 5 bits in the 32-bit class.
- R6: NEG returns the two's complement of the destination and ignores the source.
- R7: In the 32-bit class (`wide`=0), only the low 32 bits of each operand are used, and bits 63:32 of the result are zero.
- R8: With `use_imm`=1 the immediate is the source. In the 64-bit class it is sign-extended from bit 31. In the 32-bit class it is zero-extended.
- R9: DIV returns the unsigned quotient and MOD the unsigned remainder. With a non-zero divisor, `done` rises 65 edges after the start edge in the 64-bit class and 33 edges after it in the 32-bit class.
- R10: DIV with a zero divisor returns zero one cycle after start.
- R11: MOD with a zero divisor returns the destination unchanged in the 64-bit class. In the 32-bit class it returns the low 32 bits of the destination with bits 63:32 cleared. Either way the result comes one cycle after start.
- R12: A `start` that arrives while a divide or modulo is in progress is ignored. No extra `done` appears, and the pending result is not disturbed.
- R13: The reserved codes 0xd, 0xe and 0xf complete in one cycle and return all 64 bits of the destination unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Issue strobe, sampled in IDLE |
| op_code | input | 4 | Operation selector |
| wide | input | 1 | 1 = 64-bit class, 0 = 32-bit class |
| use_imm | input | 1 | 1 = immediate source, 0 = register source |
| dst_in | input | 64 | Current destination value |
| src_reg | input | 64 | Register source value |
| imm | input | 32 | Immediate field |
| result | output | 64 | New destination value, valid while `done` is high |
| done | output | 1 | One-cycle completion pulse |

## Verification
The assertions assume three things about the inputs:
- Operand and opcode inputs are only meaningful in the cycle in which `start` is sampled in IDLE.
- Reset is released away from a clock edge.
- Operands need not be held during a divide, because the unit captures them when it accepts the operation.

The zero-divisor properties work out the divisor directly from `use_imm`, `wide`, `src_reg` and `imm`, so they hold for any stimulus. The bench drives every input on the falling edge. It pulses `start` for exactly one cycle and waits for `done` before issuing again, except in the scenario that deliberately strikes `start` in the middle of a divide.

// File: rtl/vmalu_pkg.sv
package vmalu_pkg;

    localparam logic [3:0] OP_ADD  = 4'h0;
    localparam logic [3:0] OP_SUB  = 4'h1;
    localparam logic [3:0] OP_MUL  = 4'h2;
    localparam logic [3:0] OP_DIV  = 4'h3;
    localparam logic [3:0] OP_OR   = 4'h4;
    localparam logic [3:0] OP_AND  = 4'h5;
    localparam logic [3:0] OP_LSH  = 4'h6;
    localparam logic [3:0] OP_RSH  = 4'h7;
    localparam logic [3:0] OP_NEG  = 4'h8;
    localparam logic [3:0] OP_MOD  = 4'h9;
    localparam logic [3:0] OP_XOR  = 4'ha;
    localparam logic [3:0] OP_MOV  = 4'hb;
    localparam logic [3:0] OP_ARSH = 4'hc;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_DIVIDE = 2'd1,
        ST_FINISH = 2'd2
    } alu_state_e;

    function automatic logic is_divmod(input logic [3:0] op);
        return (op == OP_DIV) || (op == OP_MOD);
    endfunction

endpackage

// File: rtl/vmalu_operand_prep.sv
module vmalu_operand_prep #(
    parameter int XLEN = 64
) (
    input  logic                wide,
    input  logic                use_imm,
    input  logic [XLEN-1:0]     dst_in,
    input  logic [XLEN-1:0]     src_reg,
    input  logic [XLEN/2-1:0]   imm,
    output logic [XLEN-1:0]     opa,
    output logic [XLEN-1:0]     opb,
    output logic                divisor_zero
);
    localparam int HW = XLEN / 2;

    logic [XLEN-1:0] imm_ext;
    logic [XLEN-1:0] src_sel;

    always_comb begin
        if (wide) begin
            imm_ext = {{HW{imm[HW-1]}}, imm};
        end else begin
            imm_ext = {{HW{1'b0}}, imm};
        end
        src_sel = use_imm ? imm_ext : src_reg;
        if (wide) begin
            opa = dst_in;
            opb = src_sel;
        end else begin
            opa = {{HW{1'b0}}, dst_in[HW-1:0]};
            opb = {{HW{1'b0}}, src_sel[HW-1:0]};
        end
        divisor_zero = (opb == '0);
    end

endmodule

// File: rtl/vmalu_single.sv
module vmalu_single
    import vmalu_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic [3:0]       op,
    input  logic             wide,
    input  logic [XLEN-1:0]  opa,
    input  logic [XLEN-1:0]  opb,
    input  logic [XLEN-1:0]  dst_full,
    output logic [XLEN-1:0]  res
);
    localparam int HW  = XLEN / 2;
    localparam int SHW = $clog2(XLEN);

    logic [SHW-1:0]  shamt;
    logic [XLEN-1:0] arsh_src;
    logic [XLEN-1:0] raw;
    logic            reserved;

    always_comb begin
        if (wide) begin
            shamt    = opb[SHW-1:0];
            arsh_src = opa;
        end else begin
            shamt    = {1'b0, opb[SHW-2:0]};
            arsh_src = {{HW{opa[HW-1]}}, opa[HW-1:0]};
        end
    end

    always_comb begin
        reserved = 1'b0;
        unique case (op)
            OP_ADD:  raw = opa + opb;
            OP_SUB:  raw = opa - opb;
            OP_MUL:  raw = opa * opb;
            OP_DIV:  raw = '0;
            OP_OR:   raw = opa | opb;
            OP_AND:  raw = opa & opb;
            OP_LSH:  raw = opa << shamt;
            OP_RSH:  raw = opa >> shamt;
            OP_NEG:  raw = '0 - opa;
            OP_MOD:  raw = opa;
            OP_XOR:  raw = opa ^ opb;
            OP_MOV:  raw = opb;
            OP_ARSH: raw = $unsigned($signed(arsh_src) >>> shamt);
            default: begin
                raw      = dst_full;
                reserved = 1'b1;
            end
        endcase
    end

    always_comb begin
        if (reserved || wide) begin
            res = raw;
        end else begin
            res = {{HW{1'b0}}, raw[HW-1:0]};
        end
    end

endmodule

// File: rtl/vmalu_divider.sv
module vmalu_divider #(
    parameter int XLEN = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             wide,
    input  logic [XLEN-1:0]  dividend,
    input  logic [XLEN-1:0]  divisor,
    output logic             last,
    output logic [XLEN-1:0]  quotient,
    output logic [XLEN-1:0]  remainder
);
    localparam int HW = XLEN / 2;
    localparam int CW = $clog2(XLEN);
    localparam logic [CW-1:0] STEPS_W = CW'(XLEN - 1);
    localparam logic [CW-1:0] STEPS_N = CW'(HW - 1);

    logic [XLEN-1:0] rem_q;
    logic [XLEN-1:0] quo_q;
    logic [XLEN-1:0] dvs_q;
    logic [CW-1:0]   cnt_q;
    logic            run_q;
    logic            wide_q;

    logic [XLEN:0]   trial;
    logic [XLEN:0]   diff;
    logic            fits;

    always_comb begin
        trial = {rem_q, quo_q[XLEN-1]};
        diff  = trial - {1'b0, dvs_q};
        fits  = (trial >= {1'b0, dvs_q});
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rem_q  <= '0;
            quo_q  <= '0;
            dvs_q  <= '0;
            cnt_q  <= '0;
            run_q  <= 1'b0;
            wide_q <= 1'b0;
        end else if (load) begin
            rem_q  <= '0;
            quo_q  <= wide ? dividend : {dividend[HW-1:0], {HW{1'b0}}};
            dvs_q  <= divisor;
            cnt_q  <= wide ? STEPS_W : STEPS_N;
            run_q  <= 1'b1;
            wide_q <= wide;
        end else if (run_q) begin
            rem_q <= fits ? diff[XLEN-1:0] : trial[XLEN-1:0];
            quo_q <= {quo_q[XLEN-2:0], fits};
            cnt_q <= cnt_q - 1'b1;
            if (cnt_q == '0) begin
                run_q <= 1'b0;
            end
        end
    end

    assign last      = run_q && (cnt_q == '0);
    assign quotient  = wide_q ? quo_q : {{HW{1'b0}}, quo_q[HW-1:0]};
    assign remainder = wide_q ? rem_q : {{HW{1'b0}}, rem_q[HW-1:0]};

endmodule

// File: rtl/pfvm_alu.sv
module pfvm_alu
    import vmalu_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [3:0]          op_code,
    input  logic                wide,
    input  logic                use_imm,
    input  logic [XLEN-1:0]     dst_in,
    input  logic [XLEN-1:0]     src_reg,
    input  logic [XLEN/2-1:0]   imm,
    output logic [XLEN-1:0]     result,
    output logic                done
);
    alu_state_e state_q;
    alu_state_e state_d;

    logic [XLEN-1:0] opa;
    logic [XLEN-1:0] opb;
    logic            divisor_zero;
    logic [XLEN-1:0] single_res;
    logic            div_load;
    logic            div_last;
    logic [XLEN-1:0] div_quo;
    logic [XLEN-1:0] div_rem;
    logic            want_rem_q;
    logic [XLEN-1:0] result_q;
    logic            done_q;

    vmalu_operand_prep #(.XLEN(XLEN)) u_prep (
        .wide         (wide),
        .use_imm      (use_imm),
        .dst_in       (dst_in),
        .src_reg      (src_reg),
        .imm          (imm),
        .opa          (opa),
        .opb          (opb),
        .divisor_zero (divisor_zero)
    );

    vmalu_single #(.XLEN(XLEN)) u_single (
        .op       (op_code),
        .wide     (wide),
        .opa      (opa),
        .opb      (opb),
        .dst_full (dst_in),
        .res      (single_res)
    );

    assign div_load = (state_q == ST_IDLE) && start && is_divmod(op_code) && !divisor_zero;

    vmalu_divider #(.XLEN(XLEN)) u_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (div_load),
        .wide      (wide),
        .dividend  (opa),
        .divisor   (opb),
        .last      (div_last),
        .quotient  (div_quo),
        .remainder (div_rem)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (div_load) state_d = ST_DIVIDE;
            ST_DIVIDE: if (div_last) state_d = ST_FINISH;
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // Output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            result_q   <= '0;
            done_q     <= 1'b0;
            want_rem_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (div_load) begin
                        want_rem_q <= (op_code == OP_MOD);
                    end else if (start) begin
                        result_q <= single_res;
                        done_q   <= 1'b1;
                    end
                end
                ST_DIVIDE: begin
                end
                ST_FINISH: begin
                    result_q <= want_rem_q ? div_rem : div_quo;
                    done_q   <= 1'b1;
                end
                default: begin
                end
            endcase
        end
    end

    assign result = result_q;
    assign done   = done_q;

endmodule

// File: rtl/vmalu_checker.sv
module vmalu_checker
    import vmalu_pkg::*;
#(
    parameter int XLEN = 64
) (
    input logic               clk,
    input logic               rst_n,
    input logic               start,
    input logic [3:0]         op_code,
    input logic               wide,
    input logic               use_imm,
    input logic [XLEN-1:0]    dst_in,
    input logic [XLEN-1:0]    src_reg,
    input logic [XLEN/2-1:0]  imm,
    input logic [XLEN-1:0]    result,
    input logic               done,
    input alu_state_e         state_q
);
    localparam int HW = XLEN / 2;

    logic       zdiv;
    logic       accept;
    logic       narrow_q;
    logic       pend_q;
    logic [7:0] lat_q;
    logic [7:0] need_q;

    assign zdiv   = use_imm ? (imm == '0) : (wide ? (src_reg == '0) : (src_reg[HW-1:0] == '0));
    assign accept = (state_q == ST_IDLE) && start;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            narrow_q <= 1'b0;
            pend_q   <= 1'b0;
            lat_q    <= '0;
            need_q   <= '0;
        end else begin
            if (accept) begin
                narrow_q <= !wide && (op_code <= OP_ARSH);
            end
            if (accept && is_divmod(op_code) && !zdiv) begin
                pend_q <= 1'b1;
                lat_q  <= '0;
                need_q <= wide ? 8'(XLEN + 1) : 8'(HW + 1);
            end else if (pend_q) begin
                if (done) begin
                    pend_q <= 1'b0;
                end else begin
                    lat_q <= lat_q + 1'b1;
                end
            end
        end
    end

    assert_done_source_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (($past(state_q) == ST_FINISH) || ($past(state_q) == ST_IDLE && $past(start))));

    assert_narrow_zext_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && narrow_q) |-> (result[XLEN-1:HW] == '0));

    assert_div_latency_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (done && pend_q) |-> (lat_q == need_q));

    assert_div_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && op_code == OP_DIV && zdiv) |=> (done && result == '0));

    assert_mod_zero_wide_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && op_code == OP_MOD && zdiv && wide) |=> (done && result == $past(dst_in)));

    assert_mod_zero_narrow_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && op_code == OP_MOD && zdiv && !wide) |=>
            (done && result == {{HW{1'b0}}, $past(dst_in[HW-1:0])}));

    assert_quiet_while_busy_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DIVIDE) |-> !done);

endmodule

bind pfvm_alu vmalu_checker #(.XLEN(XLEN)) i_vmalu_checker (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .op_code (op_code),
    .wide    (wide),
    .use_imm (use_imm),
    .dst_in  (dst_in),
    .src_reg (src_reg),
    .imm     (imm),
    .result  (result),
    .done    (done),
    .state_q (state_q)
);

// File: tb/test_pfvm_alu.sv
module test_pfvm_alu;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [3:0]  op_code = 4'h0;
    logic        wide = 1'b1;
    logic        use_imm = 1'b0;
    logic [63:0] dst_in = '0;
    logic [63:0] src_reg = '0;
    logic [31:0] imm = '0;
    logic [63:0] result;
    logic        done;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;

    pfvm_alu i_pfvm_alu (
        .clk(clk), .rst_n(rst_n), .start(start), .op_code(op_code), .wide(wide),
        .use_imm(use_imm), .dst_in(dst_in), .src_reg(src_reg), .imm(imm),
        .result(result), .done(done)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > WATCHDOG) begin
            n_fail = n_fail + 1;
            $display("FAIL watchdog: run hung, actual %0d cycles expected < %0d", cycles, WATCHDOG);
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    function automatic logic [63:0] model(input logic [3:0] op, input logic w, input logic sel,
                                          input logic [63:0] d, input logic [63:0] s, input logic [31:0] im);
        logic [63:0] a, b, r;
        logic [5:0]  sh;
        b = sel ? (w ? {{32{im[31]}}, im} : {32'h0, im}) : s;
        if (w) a = d; else begin a = {32'h0, d[31:0]}; b = {32'h0, b[31:0]}; end
        sh = w ? b[5:0] : {1'b0, b[4:0]};
        case (op)
            4'h0: r = a + b;
            4'h1: r = a - b;
            4'h2: r = a * b;
            4'h3: r = (b == 0) ? 64'h0 : a / b;
            4'h4: r = a | b;
            4'h5: r = a & b;
            4'h6: r = a << sh;
            4'h7: r = a >> sh;
            4'h8: r = -a;
            4'h9: r = (b == 0) ? a : a % b;
            4'ha: r = a ^ b;
            4'hb: r = b;
            4'hc: r = w ? $unsigned($signed(a) >>> sh)
                        : $unsigned($signed({{32{a[31]}}, a[31:0]}) >>> sh);
            default: return d;
        endcase
        return w ? r : {32'h0, r[31:0]};
    endfunction

    function automatic int model_lat(input logic [3:0] op, input logic w, input logic sel,
                                     input logic [63:0] s, input logic [31:0] im);
        logic [63:0] b;
        b = sel ? (w ? {{32{im[31]}}, im} : {32'h0, im}) : s;
        if (!w) b = {32'h0, b[31:0]};
        if ((op == 4'h3 || op == 4'h9) && b != 0) return w ? 65 : 33;
        return 0;
    endfunction

    task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
        n_checks = n_checks + 1;
        if (got !== exp) begin
            n_fail = n_fail + 1;
            $display("FAIL %s: actual %h expected %h", tag, got, exp);
        end
    endtask

    task automatic issue(input logic [3:0] op, input logic w, input logic sel,
                         input logic [63:0] d, input logic [63:0] s, input logic [31:0] im,
                         output logic [63:0] res, output int lat);
        @(negedge clk);
        op_code = op; wide = w; use_imm = sel; dst_in = d; src_reg = s; imm = im; start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        lat = 0;
        while (!done && lat < 200) begin
            @(posedge clk);
            lat = lat + 1;
            @(negedge clk);
        end
        res = result;
    endtask

    task automatic run_op(input string tag, input logic [3:0] op, input logic w, input logic sel,
                          input logic [63:0] d, input logic [63:0] s, input logic [31:0] im);
        logic [63:0] res;
        int lat;
        issue(op, w, sel, d, s, im, res, lat);
        check(tag, res, model(op, w, sel, d, s, im));
        check({tag, " latency"}, 64'(lat), 64'(model_lat(op, w, sel, s, im)));
    endtask

    task automatic test_reset;
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 reset done", {63'h0, done}, 64'h0);
        check("R1 reset result", result, 64'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after release", {63'h0, done}, 64'h0);
    endtask

    task automatic test_wrap;
        run_op("R3 add wrap 64", 4'h0, 1'b1, 1'b0, 64'hffff_ffff_ffff_ffff, 64'h2, 32'h0);
        run_op("R3 sub wrap 32", 4'h1, 1'b0, 1'b0, 64'hdead_0000_0000_0000, 64'h1, 32'h0);
        run_op("R3 mul 64", 4'h2, 1'b1, 1'b0, 64'h1234_5678_9abc_def1, 64'hfedc_ba98_7654_3211, 32'h0);
        run_op("R3 mul 32", 4'h2, 1'b0, 1'b0, 64'h0000_0001_ffff_fffe, 64'hffff_0000_0003_0001, 32'h0);
    endtask

    task automatic test_logic;
        run_op("R4 or", 4'h4, 1'b1, 1'b0, 64'hf0f0_0000_1111_0000, 64'h0f00_ff00_0000_000f, 32'h0);
        run_op("R4 and", 4'h5, 1'b1, 1'b0, 64'hffff_0000_ffff_0000, 64'h1234_5678_9abc_def0, 32'h0);
        run_op("R4 xor", 4'ha, 1'b1, 1'b0, 64'haaaa_aaaa_5555_5555, 64'hffff_0000_ffff_0000, 32'h0);
        run_op("R4 mov", 4'hb, 1'b1, 1'b0, 64'h1111, 64'h8765_4321_0fed_cba9, 32'h0);
    endtask

    task automatic test_shifts;
        run_op("R5 lsh 64 masked", 4'h6, 1'b1, 1'b0, 64'h1, 64'h43, 32'h0);
        run_op("R5 rsh 32 masked", 4'h7, 1'b0, 1'b0, 64'hffff_ffff_8000_0000, 64'h24, 32'h0);
        run_op("R5 arsh 64", 4'hc, 1'b1, 1'b0, 64'h8000_0000_0000_0000, 64'h3c, 32'h0);
        run_op("R5 arsh 32", 4'hc, 1'b0, 1'b0, 64'h0000_0000_8000_0010, 64'h4, 32'h0);
    endtask

    task automatic test_neg_narrow;
        run_op("R6 neg ignores src", 4'h8, 1'b1, 1'b0, 64'h5, 64'hffff_ffff_ffff_ffff, 32'h0);
        run_op("R7 add 32 upper ignored", 4'h0, 1'b0, 1'b0, 64'hffff_ffff_0000_0001, 64'h1234_5678_0000_0002, 32'h0);
        run_op("R7 neg 32", 4'h8, 1'b0, 1'b0, 64'hffff_0000_0000_0001, 64'h0, 32'h0);
    endtask

    task automatic test_imm;
        run_op("R8 imm sext 64", 4'h0, 1'b1, 1'b1, 64'h10, 64'h0, 32'hffff_fff0);
        run_op("R8 imm zext 32", 4'hb, 1'b0, 1'b1, 64'h10, 64'h0, 32'h8000_0000);
        run_op("R8 div imm sext", 4'h3, 1'b1, 1'b1, 64'hffff_ffff_ffff_ffff, 64'h0, 32'hffff_ffff);
        run_op("R8 div imm zext", 4'h3, 1'b0, 1'b1, 64'h0000_0000_ffff_ffff, 64'h0, 32'hffff_ffff);
    endtask

    task automatic test_divmod;
        run_op("R9 div 64", 4'h3, 1'b1, 1'b0, 64'd1000, 64'd7, 32'h0);
        run_op("R9 mod 64", 4'h9, 1'b1, 1'b0, 64'd1000, 64'd7, 32'h0);
        run_op("R9 div 64 large", 4'h3, 1'b1, 1'b0, 64'hfedc_ba98_7654_3210, 64'h0000_0001_0000_0003, 32'h0);
        run_op("R9 mod 32", 4'h9, 1'b0, 1'b0, 64'hffff_ffff_ffff_fff0, 64'hffff_0000_0000_000d, 32'h0);
        run_op("R9 div 32", 4'h3, 1'b0, 1'b0, 64'h1111_1111_8000_0001, 64'h2, 32'h0);
    endtask

    task automatic test_zero_div;
        run_op("R10 div zero 64", 4'h3, 1'b1, 1'b0, 64'h1234_5678_9abc_def0, 64'h0, 32'h0);
        run_op("R10 div zero 32 upper src", 4'h3, 1'b0, 1'b0, 64'h55, 64'hffff_ffff_0000_0000, 32'h0);
        run_op("R11 mod zero 64", 4'h9, 1'b1, 1'b0, 64'hdead_beef_cafe_f00d, 64'h0, 32'h0);
        run_op("R11 mod zero 32", 4'h9, 1'b0, 1'b1, 64'hdead_beef_cafe_f00d, 64'h0, 32'h0);
    endtask

    task automatic test_busy;
        int lat;
        @(negedge clk);
        op_code = 4'h3; wide = 1'b1; use_imm = 1'b0; dst_in = 64'd999; src_reg = 64'd10; start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        lat = 0;
        while (!done && lat < 200) begin
            if (lat == 5) begin
                op_code = 4'h0; dst_in = 64'h7; src_reg = 64'h7; start = 1'b1;
            end else begin
                start = 1'b0;
            end
            @(posedge clk);
            lat = lat + 1;
            @(negedge clk);
        end
        start = 1'b0;
        check("R12 busy latency", 64'(lat), 64'd65);
        check("R12 busy result", result, 64'd99);
        @(negedge clk);
        check("R12 no extra done", {63'h0, done}, 64'h0);
        check("R12 result kept", result, 64'd99);
    endtask

    task automatic test_reserved;
        for (int c = 13; c < 16; c++) begin
            run_op("R13 reserved", 4'(c), 1'b0, 1'b0, 64'hfeed_face_0bad_c0de, 64'h1, 32'h0);
        end
        run_op("R2 done pulse add", 4'h0, 1'b1, 1'b1, 64'h1, 64'h0, 32'h1);
        @(negedge clk);
        check("R2 done one cycle", {63'h0, done}, 64'h0);
    endtask

    initial begin
        test_reset;
        test_wrap;
        test_logic;
        test_shifts;
        test_neg_narrow;
        test_imm;
        test_divmod;
        test_zero_div;
        test_busy;
        test_reserved;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule